// File: doc/BRIEF.md
# Synchronous Muxed-Bus Register and Burst Slave

This block is a slave on a 16-bit multiplexed address/data bus that runs from the bus clock. The host opens each access by holding address valid low while the offset sits on the AD lines. It then asserts chip select, and after that either write enable or output enable. The slave samples every strobe on the rising bus clock. It holds the offset captured during the address phase and counts the cycles of the access. It decodes three locations: a fixed version byte, a control/status byte, and a data port that drains an external FIFO.

Writes update the control byte. A read of a register returns one word at a fixed latency. A read of the data port returns a synchronous burst of one word per clock, and every word pops one FIFO entry. Only the low byte of the bus carries data, and the high byte is always zero. The AD bus drive enable is raised only while chip select and output enable are both low. The capture logic that fills the FIFO, and the FIFO storage itself, sit outside this block. The capture side reports overflow events through a single pulse input.

Top module: `cambus_top`

## Requirements
- R1: After reset the drive enable, the read word, the FIFO pop and all four control outputs are 0.
- R2: A read at offset 0x00 returns the ID_VAL parameter on AD[7:0] during cycle 14 of the access. Cycle 0 is the first cycle in which address valid is sampled low.
- R3: A write at offset 0x02 stores AD[7:3]. These bits are sampled on the first clock edge that sees write enable low with chip select low. Bit 3 drives dma_burst4_o, bit 4 drives capture_en_o, bit 6 drives pclk_fall_o and bit 7 drives fmt_rgb_o. Bit 5 is stored and can be read back. The offset is taken during the address phase, so later AD values do not change the decode.
- R4: Reading offset 0x02 returns the stored bits 7..3, 0 in bit 2, the overflow flag in bit 1 and the FIFO-empty input in bit 0.
- R5: An overflow event pulse sets the flag. The clock edge that loads a control read clears the flag, so the flag reads 1 once and then 0. If an event arrives on that same edge, the read returns the old value and the flag stays set.
- R6: A read at offset 0x80 returns 16 words on cycles 14 to 29. Each word carries the next FIFO byte in order, and each word pops exactly one entry.
- R7: A burst word that finds the FIFO empty reads as zero and does not pop.
- R8: ad_oe_o is 1 exactly when chip select and output enable are both low. The AD high byte is always zero.
- R9: Reads of any other offset return zero, and writes to any other offset leave the control byte unchanged.
- R10: Register reads never pop the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| adv_ni | input | 1 | Address valid, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| ad_i | input | 16 | AD bus value sampled from the pins |
| ad_o | output | 16 | AD bus value to drive |
| ad_oe_o | output | 1 | Drive enable for the AD pads |
| fifo_empty_i | input | 1 | FIFO holds no entry |
| fifo_data_i | input | 8 | Head entry of the FIFO |
| fifo_pop_o | output | 1 | Remove the head entry on this edge |
| ovf_set_i | input | 1 | Overflow event pulse from the capture side |
| dma_burst4_o | output | 1 | Request size select (control bit 3) |
| capture_en_o | output | 1 | Capture enable (control bit 4) |
| pclk_fall_o | output | 1 | Pixel clock falling-edge select (control bit 6) |
| fmt_rgb_o | output | 1 | Data format select (control bit 7) |

## Verification
Two functions can land on the same clock edge: an overflow event from the capture side, and the read-to-clear of the control byte. The bench pulses the event during cycle 13 of a control read, which is the edge that loads the read word. It then expects the returned bit 1 to show the old flag value, the next control read to return 1, and the read after that to return 0. A second collision occurs between a burst and a draining FIFO. The bench starts a burst with fewer than 16 entries queued and checks that the tail words are zero and that no extra pops occur.

// File: rtl/cambus_pkg.sv
package cambus_pkg;
  localparam int OFS_ID   = 'h00;
  localparam int OFS_CTRL = 'h02;
  localparam int OFS_DATA = 'h80;
  localparam int BYTE_W   = 8;

  typedef struct packed {
    logic fmt_rgb;    // bit 7
    logic pclk_fall;  // bit 6
    logic spare;      // bit 5
    logic cap_en;     // bit 4
    logic dma4;       // bit 3
  } ctrl_wr_t;
endpackage

// File: rtl/cambus_acc.sv
module cambus_acc #(
  parameter int AD_W  = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             adv_ni,
  input  logic [AD_W-1:0]  ad_i,
  output logic             acc_o,
  output logic [CNT_W-1:0] cyc_o,
  output logic [AD_W-1:0]  addr_o
);
  localparam logic [CNT_W-1:0] CYC_MAX = '1;

  // cyc_o holds the index of the current access cycle (cycle 0 = first adv low)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= 1'b0;
      cyc_o  <= '0;
      addr_o <= '0;
    end else if (!acc_o) begin
      if (!adv_ni) begin
        acc_o  <= 1'b1;
        cyc_o  <= CNT_W'(1);
        addr_o <= ad_i;
      end
    end else if (cs_ni && cyc_o >= CNT_W'(2)) begin
      acc_o <= 1'b0;
      cyc_o <= '0;
    end else begin
      if (!adv_ni) addr_o <= ad_i;
      if (cyc_o != CYC_MAX) cyc_o <= cyc_o + 1'b1;
    end
  end
endmodule

// File: rtl/cambus_regs.sv
module cambus_regs
  import cambus_pkg::*;
#(
  parameter int          AD_W   = 16,
  parameter logic [7:0]  ID_VAL = 8'hA7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic            cs_ni,
  input  logic            we_ni,
  input  logic [AD_W-1:0] addr_i,
  input  logic [7:0]      wdata_i,
  input  logic            rd_clr_i,
  input  logic            ovf_set_i,
  input  logic            fifo_empty_i,
  output ctrl_wr_t        ctrl_o,
  output logic            ovf_o,
  output logic [7:0]      rdata_o
);
  logic wr_done_q;
  logic is_ctrl;
  logic wr_fire;

  assign is_ctrl = (addr_i == AD_W'(OFS_CTRL));
  assign wr_fire = acc_i && !cs_ni && !we_ni && !wr_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      wr_done_q <= 1'b0;
    end else begin
      if (!acc_i)       wr_done_q <= 1'b0;
      else if (wr_fire) wr_done_q <= 1'b1;
      if (wr_fire && is_ctrl) ctrl_o <= ctrl_wr_t'(wdata_i[7:3]);
    end
  end

  // new event wins over read-clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_o <= 1'b0;
    else if (ovf_set_i) ovf_o <= 1'b1;
    else if (rd_clr_i)  ovf_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AD_W'(OFS_ID)) rdata_o = ID_VAL;
    else if (is_ctrl)            rdata_o = {ctrl_o, 1'b0, ovf_o, fifo_empty_i};
  end
endmodule

// File: rtl/cambus_rd.sv
module cambus_rd
  import cambus_pkg::*;
#(
  parameter int AD_W       = 16,
  parameter int CNT_W      = 6,
  parameter int FIRST_BEAT = 14,
  parameter int BURST_LEN  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [AD_W-1:0]  addr_i,
  input  logic             oe_ni,
  input  logic             we_ni,
  input  logic             fifo_empty_i,
  input  logic [7:0]       fifo_data_i,
  input  logic [7:0]       reg_rdata_i,
  output logic [7:0]       rd_byte_o,
  output logic             fifo_pop_o,
  output logic             reg_rd_o
);
  localparam int BW = $clog2(BURST_LEN + 1);

  logic [BW-1:0] beats_q;
  logic is_data, first, more, beat;

  assign is_data    = (addr_i == AD_W'(OFS_DATA));
  // load on the edge ending cycle FIRST_BEAT-1 so the word shows in FIRST_BEAT
  assign first      = acc_i && !oe_ni && we_ni && (cyc_i == CNT_W'(FIRST_BEAT - 1));
  assign more       = acc_i && !oe_ni && (beats_q != '0);
  assign beat       = (first && is_data) || more;
  assign fifo_pop_o = beat && !fifo_empty_i;
  assign reg_rd_o   = first && !is_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beats_q   <= '0;
      rd_byte_o <= '0;
    end else begin
      if (!acc_i)               beats_q <= '0;
      else if (first && is_data) beats_q <= BW'(BURST_LEN - 1);
      else if (more)            beats_q <= beats_q - 1'b1;

      if (beat)          rd_byte_o <= fifo_empty_i ? '0 : fifo_data_i;
      else if (reg_rd_o) rd_byte_o <= reg_rdata_i;
      else               rd_byte_o <= '0;
    end
  end
endmodule

// File: rtl/cambus_top.sv
module cambus_top
  import cambus_pkg::*;
#(
  parameter int         AD_W       = 16,
  parameter int         FIRST_BEAT = 14,
  parameter int         BURST_LEN  = 16,
  parameter logic [7:0] ID_VAL     = 8'hA7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            adv_ni,
  input  logic            oe_ni,
  input  logic            we_ni,
  input  logic [AD_W-1:0] ad_i,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe_o,
  input  logic            fifo_empty_i,
  input  logic [7:0]      fifo_data_i,
  output logic            fifo_pop_o,
  input  logic            ovf_set_i,
  output logic            dma_burst4_o,
  output logic            capture_en_o,
  output logic            pclk_fall_o,
  output logic            fmt_rgb_o
);
  localparam int CNT_W = $clog2(FIRST_BEAT + BURST_LEN + 32);

  logic             acc;
  logic [CNT_W-1:0] cyc;
  logic [AD_W-1:0]  addr;
  ctrl_wr_t         ctrl;
  logic             ovf_q;
  logic [7:0]       reg_rdata;
  logic [7:0]       rd_byte;
  logic             reg_rd;
  logic             rd_clr;

  cambus_acc #(.AD_W(AD_W), .CNT_W(CNT_W)) u_acc (
    .clk_i, .rst_ni, .cs_ni, .adv_ni, .ad_i,
    .acc_o(acc), .cyc_o(cyc), .addr_o(addr)
  );

  assign rd_clr = reg_rd && (addr == AD_W'(OFS_CTRL));

  cambus_regs #(.AD_W(AD_W), .ID_VAL(ID_VAL)) u_regs (
    .clk_i, .rst_ni, .acc_i(acc), .cs_ni, .we_ni, .addr_i(addr),
    .wdata_i(ad_i[7:0]), .rd_clr_i(rd_clr), .ovf_set_i, .fifo_empty_i,
    .ctrl_o(ctrl), .ovf_o(ovf_q), .rdata_o(reg_rdata)
  );

  cambus_rd #(.AD_W(AD_W), .CNT_W(CNT_W), .FIRST_BEAT(FIRST_BEAT),
              .BURST_LEN(BURST_LEN)) u_rd (
    .clk_i, .rst_ni, .acc_i(acc), .cyc_i(cyc), .addr_i(addr), .oe_ni, .we_ni,
    .fifo_empty_i, .fifo_data_i, .reg_rdata_i(reg_rdata),
    .rd_byte_o(rd_byte), .fifo_pop_o, .reg_rd_o(reg_rd)
  );

  assign ad_o         = {{(AD_W-8){1'b0}}, rd_byte};
  assign ad_oe_o      = !cs_ni && !oe_ni;
  assign dma_burst4_o = ctrl.dma4;
  assign capture_en_o = ctrl.cap_en;
  assign pclk_fall_o  = ctrl.pclk_fall;
  assign fmt_rgb_o    = ctrl.fmt_rgb;
endmodule

// File: rtl/cambus_chk.sv
module cambus_chk #(
  parameter int BURST_LEN = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       oe_ni,
  input logic       we_ni,
  input logic       fifo_empty_i,
  input logic       fifo_pop_o,
  input logic       ovf_set_i,
  input logic       ovf_q,
  input logic       rd_clr,
  input logic [3:0] ctrl_outs
);
  localparam int PW = $clog2(BURST_LEN + 2);
  logic [PW-1:0] pop_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pop_cnt <= '0;
    else if (cs_ni)      pop_cnt <= '0;
    else if (fifo_pop_o) pop_cnt <= pop_cnt + 1'b1;
  end

  a_r7_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  a_r6_pop_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (!cs_ni && we_ni && !oe_ni));

  a_r6_burst_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (pop_cnt < PW'(BURST_LEN)));

  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_q);

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && !ovf_set_i) |=> !ovf_q);

  a_r3_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_outs) |-> $past(!we_ni && !cs_ni));
endmodule

bind cambus_top cambus_chk #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .oe_ni(oe_ni), .we_ni(we_ni),
  .fifo_empty_i(fifo_empty_i), .fifo_pop_o(fifo_pop_o), .ovf_set_i(ovf_set_i),
  .ovf_q(ovf_q), .rd_clr(rd_clr),
  .ctrl_outs({fmt_rgb_o, pclk_fall_o, capture_en_o, dma_burst4_o})
);

// File: tb/tb_cambus_top.sv
`timescale 1ns/1ps
module tb_cambus_top;
  localparam logic [7:0] EXP_ID = 8'hA7;
  localparam int FIRST = 14;
  localparam int BURST = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, adv_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o;
  logic ad_oe_o, fifo_pop_o, ovf_set_i = 1'b0;
  logic dma_burst4_o, capture_en_o, pclk_fall_o, fmt_rgb_o;
  logic fifo_empty_i;
  logic [7:0] fifo_data_i;

  logic [7:0] fmem [0:63];
  int wp = 0, rp = 0, pops = 0;
  int checks = 0, fails = 0, drive_err = 0;
  logic [15:0] rw [0:15];
  logic [7:0] ctrl_m = '0;
  logic ovf_m = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  assign fifo_empty_i = (wp == rp);
  assign fifo_data_i  = fmem[rp & 63];

  always @(posedge clk) if (fifo_pop_o && rp != wp) begin
    rp <= rp + 1;
    pops <= pops + 1;
  end

  cambus_top #(.ID_VAL(EXP_ID)) dut (
    .clk_i(clk), .rst_ni, .cs_ni, .adv_ni, .oe_ni, .we_ni, .ad_i, .ad_o, .ad_oe_o,
    .fifo_empty_i, .fifo_data_i, .fifo_pop_o, .ovf_set_i,
    .dma_burst4_o, .capture_en_o, .pclk_fall_o, .fmt_rgb_o
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl(input logic [7:0] c, input logic o, input logic e);
    return {c[7:3], 1'b0, o, e};
  endfunction

  task automatic push(input logic [7:0] v);
    fmem[wp & 63] = v;
    wp++;
  endtask

  task automatic idle();
    @(negedge clk);
    cs_ni = 1; adv_ni = 1; oe_ni = 1; we_ni = 1; ad_i = '0; ovf_set_i = 0;
    #1;
    if (ad_oe_o !== 1'b0) drive_err++;
  endtask

  // ovf_at: access cycle in which an overflow event is pulsed (-1 = none)
  task automatic bus_read(input logic [15:0] a, input int ovf_at);
    int len = (a == 16'h0080) ? FIRST + BURST : 16;
    for (int c = 0; c <= len; c++) begin
      @(negedge clk);
      adv_ni = !(c <= 3);
      cs_ni = !(c >= 1 && c < len);
      oe_ni = !(c >= 6 && c < len);
      we_ni = 1;
      ad_i = (c <= 4) ? a : 16'($urandom);
      ovf_set_i = (c == ovf_at);
      #1;
      if (ad_oe_o !== (!cs_ni && !oe_ni)) drive_err++;
      if (c >= FIRST && c < FIRST + BURST) rw[c-FIRST] = ad_o;
    end
    idle();
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    for (int c = 0; c <= 31; c++) begin
      @(negedge clk);
      adv_ni = !(c <= 3);
      cs_ni = !(c >= 1 && c < 31);
      we_ni = !(c >= 6 && c < 31);
      oe_ni = 1;
      ad_i = (c <= 4) ? a : {8'($urandom), d};
      #1;
      if (ad_oe_o !== 1'b0) drive_err++;
    end
    idle();
  endtask

  task automatic check_outs(input string req);
    logic [3:0] act = {fmt_rgb_o, pclk_fall_o, capture_en_o, dma_burst4_o};
    logic [3:0] exp = {ctrl_m[7], ctrl_m[6], ctrl_m[4], ctrl_m[3]};
    chk(act === exp, req, 16'(act), 16'(exp));
  endtask

  task automatic read_ctrl(input string req);
    logic [7:0] e = exp_ctrl(ctrl_m, ovf_m, wp == rp);
    bus_read(16'h0002, -1);
    chk(rw[0] === {8'h00, e}, req, rw[0], {8'h00, e});
    ovf_m = 0;
  endtask

  task automatic burst_check(input string req);
    int avail = wp - rp;
    int r0 = rp, p0 = pops;
    int bad = 0;
    logic [15:0] ex;
    logic [15:0] bad_a = '0, bad_e = '0;
    bus_read(16'h0080, -1);
    for (int k = 0; k < BURST; k++) begin
      ex = (k < avail) ? {8'h00, fmem[(r0 + k) & 63]} : 16'h0000;
      if (rw[k] !== ex) begin bad++; bad_a = rw[k]; bad_e = ex; end
    end
    chk(bad == 0, req, bad_a, bad_e);
    ex = 16'((avail < BURST) ? avail : BURST);
    chk(pops - p0 == int'(ex), req, 16'(pops - p0), ex);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      finish_up();
    end
  end

  initial begin
    int p0;
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(ad_oe_o === 0 && ad_o === 0 && fifo_pop_o === 0, "R1", {ad_oe_o, fifo_pop_o, ad_o[13:0]}, 0);
    check_outs("R1");
    rst_ni = 1;
    idle();

    // R2 ID
    bus_read(16'h0000, -1);
    chk(rw[0] === {8'h00, EXP_ID}, "R2", rw[0], {8'h00, EXP_ID});

    // R4 empty flag, both states
    read_ctrl("R4 empty");
    push(8'h11); push(8'h22);
    read_ctrl("R4 not empty");

    // R3 directed and random writes
    bus_write(16'h0002, 8'hFF); ctrl_m = 8'hFF;
    check_outs("R3 all ones");
    read_ctrl("R3 readback ones");
    bus_write(16'h0002, 8'h00); ctrl_m = 8'h00;
    check_outs("R3 zeros");
    for (int i = 0; i < 6; i++) begin
      v = 8'($urandom);
      bus_write(16'h0002, v); ctrl_m = v;
      check_outs("R3 random");
      read_ctrl("R3 random readback");
    end

    // R9 other offsets
    bus_write(16'h0100, ~ctrl_m);
    bus_write(16'h0080, ~ctrl_m);
    check_outs("R9 write ignored");
    read_ctrl("R9 ctrl unchanged");
    bus_read(16'h0004, -1);
    chk(rw[0] === 16'h0, "R9 read 0x04", rw[0], 16'h0);
    bus_read(16'h0100, -1);
    chk(rw[0] === 16'h0, "R9 read 0x100", rw[0], 16'h0);

    // R10 register reads leave FIFO untouched
    p0 = pops;
    bus_read(16'h0000, -1);
    read_ctrl("R10 ctrl read");
    chk(pops == p0, "R10", 16'(pops), 16'(p0));

    // R5 overflow read-once
    @(negedge clk); ovf_set_i = 1; @(negedge clk); ovf_set_i = 0;
    ovf_m = 1;
    read_ctrl("R5 first read 1");
    read_ctrl("R5 second read 0");
    // R5 collision: event on the loading edge (cycle 13)
    bus_read(16'h0002, 13);
    v = exp_ctrl(ctrl_m, 1'b0, wp == rp);
    chk(rw[0] === {8'h00, v}, "R5 collide old value", rw[0], {8'h00, v});
    ovf_m = 1;
    read_ctrl("R5 collide flag kept");
    read_ctrl("R5 collide then cleared");

    // R6 full burst
    while (wp - rp < 20) push(8'($urandom));
    burst_check("R6 full burst");
    // R7 short burst drains then zeros
    burst_check("R7 short burst");
    chk(wp == rp, "R7 drained", 16'(wp - rp), 0);
    burst_check("R7 empty burst");
    // random fill levels
    for (int i = 0; i < 4; i++) begin
      int n = $urandom_range(0, 24);
      for (int k = 0; k < n; k++) push(8'($urandom));
      burst_check("R6 random burst");
      if (wp - rp > 0) burst_check("R7 random tail");
    end

    // R8 drive enable seen on every cycle of every access
    chk(drive_err == 0, "R8", 16'(drive_err), 0);
    done = 1;
    finish_up();
  end
endmodule